// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block is a hardware loop sequencer that sits next to an in-order fetch unit. Software first programs a loop start address, a loop end address and a 12-bit repeat count through a small register-write port. The loop is then armed only when a dedicated repeat-detection instruction retires without being cancelled by a taken branch. While the loop is armed, every retirement of the instruction at the loop end address produces a same-cycle fetch redirect to the loop start, and the count drops by one. When the last pass reaches the end address, fetch falls through to the next sequential address and the loop disarms.

From the cycle after the detection instruction retires until the loop exits, the block raises an exception-hold flag. Deferrable requests such as interrupts are held pending while the flag is high. A non-deferrable exception taken inside the window ends the loop: the armed state and the hold flag are dropped, and the count is kept. A branch that lands past the detection instruction arms nothing. Control pins are plain level or strobe signals with no handshake.

Top module: `rpt_loop_seq`

## Requirements
- R1: A synchronous reset clears the repeat count, the armed flag and the exception-hold flag, so the status word reads 0 in the cycle after reset.
- R2: While the loop is not armed, a write with `cfg_sel` = 0 loads the start address, 1 loads the end address, and 2 loads the repeat count from `cfg_wdata[11:0]`. Select value 3 loads nothing. The status word holds the count in bits [11:0], the hold flag in bit 12 and the armed flag in bit 13.
- R3: The loop arms in the cycle after a retirement with `ret_is_detect` high and a non-zero count. A retirement of any other instruction, including the one after the detection instruction, reached by a branch, arms nothing and leaves the count unchanged.
- R4: A detection instruction that retires in a delay slot (`ret_in_slot` = 1) arms the loop only when `ret_br_taken` = 0. When the branch is taken, the loop stays idle and the count is unchanged.
- R5: While the loop is armed, a retirement at the end address with a count greater than 1 drives `redir_valid` = 1 and `redir_pc` = start address in the same cycle. The count is one lower in the next cycle.
- R6: While the loop is armed, a retirement at the end address with a count of 1 gives no redirect. In the next cycle the count is 0, the loop is disarmed and the hold flag is low.
- R7: `exc_hold` is high from the cycle after arming until the cycle after the loop exits. `irq_accept` equals `irq_req` while `exc_hold` is low and is 0 while it is high.
- R8: `exc_abort` while the loop is armed disarms the loop and drops the hold flag in the next cycle, keeps the count, and suppresses any redirect in that cycle.
- R9: Register writes made while the loop is armed, or in the cycle it arms, are ignored. The loop then keeps using the old start address, end address and count.
- R10: A detection instruction that retires while the loop is already armed has no effect on the count or the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 start, 1 end, 2 count, 3 none |
| cfg_wdata | input | 32 | Write data |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_is_detect | input | 1 | The retiring instruction is the repeat-detection instruction |
| ret_in_slot | input | 1 | The retiring instruction sits in a branch delay slot |
| ret_br_taken | input | 1 | The branch owning that delay slot is taken |
| exc_abort | input | 1 | A non-deferrable exception is taken this cycle |
| irq_req | input | 1 | Deferrable interrupt request |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_pc | output | 32 | Redirect target (loop start) |
| exc_hold | output | 1 | Exception-hold window active |
| irq_accept | output | 1 | Interrupt may be taken now |
| status | output | 14 | {armed, hold, count[11:0]} |

## Verification
The redirect and the interrupt gate are combinational, so they are due in the same cycle as the retirement or request that causes them. The bench samples them one time unit after it drives the inputs. Count, armed and hold changes are due one clock edge later, and the bench compares the status word on the falling edge that follows that edge. A behavioural model in the bench advances at the same edge and supplies every expected value. Each comparison is tagged with the requirement of the phase under test.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned RC_W   = 12;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    LOOP_IDLE  = 1'b0,
    LOOP_ARMED = 1'b1
  } loop_state_e;

  typedef struct packed {
    logic arm;
    logic back;
    logic fin;
    logic abort;
  } loop_evt_t;
endpackage

// File: rtl/rpt_cfg_regs.sv
module rpt_cfg_regs
  import rpt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          lock,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] end_addr
);
  logic do_wr;
  assign do_wr = wr_en && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      end_addr   <= '0;
    end else if (do_wr) begin
      if (cfg_sel_e'(wr_sel) == SEL_START) start_addr <= wr_data;
      if (cfg_sel_e'(wr_sel) == SEL_END)   end_addr   <= wr_data;
    end
  end
endmodule

// File: rtl/rpt_counter.sv
module rpt_counter
  import rpt_pkg::*;
#(
  parameter int unsigned CW = RC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          cnt_nz,
  output logic          cnt_gt1,
  output logic          cnt_is1
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (clear)   count <= '0;
    else if (dec)     count <= count - ONE;
    else if (load_en) count <= load_val;
  end

  assign cnt_nz  = (count != '0);
  assign cnt_is1 = (count == ONE);
  assign cnt_gt1 = cnt_nz && !cnt_is1;
endmodule

// File: rtl/rpt_seq_fsm.sv
module rpt_seq_fsm
  import rpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  loop_evt_t evt,
  output logic      armed,
  output logic      hold
);
  loop_state_e state, state_nx;
  logic        hold_nx;

  always_comb begin
    state_nx = state;
    hold_nx  = hold;
    unique case (state)
      LOOP_IDLE: begin
        if (evt.arm) begin
          state_nx = LOOP_ARMED;
          hold_nx  = 1'b1;
        end
      end
      LOOP_ARMED: begin
        if (evt.abort || evt.fin) begin
          state_nx = LOOP_IDLE;
          hold_nx  = 1'b0;
        end
      end
      default: begin
        state_nx = LOOP_IDLE;
        hold_nx  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LOOP_IDLE;
      hold  <= 1'b0;
    end else begin
      state <= state_nx;
      hold  <= hold_nx;
    end
  end

  assign armed = (state == LOOP_ARMED);
endmodule

// File: rtl/rpt_loop_seq.sv
module rpt_loop_seq
  import rpt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = RC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           ret_valid,
  input  logic [AW-1:0]  ret_pc,
  input  logic           ret_is_detect,
  input  logic           ret_in_slot,
  input  logic           ret_br_taken,
  input  logic           exc_abort,
  input  logic           irq_req,
  output logic           redir_valid,
  output logic [AW-1:0]  redir_pc,
  output logic           exc_hold,
  output logic           irq_accept,
  output logic [CW+1:0]  status
);
  localparam int unsigned ST_W = CW + 2;

  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] rc_q;
  logic          rc_nz, rc_gt1, rc_is1;
  logic          armed;
  logic          at_end, detect_ok;
  loop_evt_t     evt;

  assign at_end    = ret_valid && (ret_pc == end_q);
  assign detect_ok = ret_valid && ret_is_detect && !(ret_in_slot && ret_br_taken);

  assign evt.arm   = !armed && detect_ok && rc_nz;
  assign evt.abort = armed && exc_abort;
  assign evt.back  = armed && !exc_abort && at_end && rc_gt1;
  assign evt.fin   = armed && !exc_abort && at_end && rc_is1;

  rpt_cfg_regs #(.AW(AW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .wr_sel     (cfg_sel),
    .wr_data    (cfg_wdata),
    .lock       (armed || evt.arm),
    .start_addr (start_q),
    .end_addr   (end_q)
  );

  rpt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_COUNT) && !armed && !evt.arm),
    .load_val (cfg_wdata[CW-1:0]),
    .dec      (evt.back),
    .clear    (evt.fin),
    .count    (rc_q),
    .cnt_nz   (rc_nz),
    .cnt_gt1  (rc_gt1),
    .cnt_is1  (rc_is1)
  );

  rpt_seq_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .armed (armed),
    .hold  (exc_hold)
  );

  assign redir_valid = evt.back;
  assign redir_pc    = start_q;
  assign irq_accept  = irq_req && !exc_hold;
  assign status      = ST_W'({armed, exc_hold, rc_q});
endmodule

// File: rtl/rpt_loop_seq_chk.sv
module rpt_loop_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          ret_valid,
  input logic [AW-1:0] ret_pc,
  input logic          ret_is_detect,
  input logic          exc_abort,
  input logic          redir_valid,
  input logic          exc_hold,
  input logic          irq_accept,
  input logic [CW+1:0] status,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] end_q
);
  logic          armed_s;
  logic [CW-1:0] rc_s;
  assign armed_s = status[CW+1];
  assign rc_s    = status[CW-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (status == '0));
  // R5
  redir_cond_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (armed_s && rc_s > CW'(1)));
  // R5
  redir_dec_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> (rc_s == $past(rc_s) - CW'(1)));
  // R6
  loop_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_s && ret_valid && ret_pc == end_q && rc_s == CW'(1) && !exc_abort)
    |=> (!armed_s && !exc_hold && rc_s == '0));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_accept |-> !exc_hold);
  // R8
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_s && exc_abort) |=> (!armed_s && !exc_hold && rc_s == $past(rc_s)));
  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    armed_s |=> ($stable(start_q) && $stable(end_q)));
  // R3
  arm_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_s) |-> $past(ret_valid && ret_is_detect));
endmodule

bind rpt_loop_seq rpt_loop_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ret_valid     (ret_valid),
  .ret_pc        (ret_pc),
  .ret_is_detect (ret_is_detect),
  .exc_abort     (exc_abort),
  .redir_valid   (redir_valid),
  .exc_hold      (exc_hold),
  .irq_accept    (irq_accept),
  .status        (status),
  .start_q       (start_q),
  .end_q         (end_q)
);

// File: tb/rpt_loop_seq_bench.sv
module rpt_loop_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic        ret_is_detect, ret_in_slot, ret_br_taken;
  logic        exc_abort, irq_req;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        exc_hold, irq_accept;
  logic [13:0] status;

  int n_chk = 0;
  int n_bad = 0;
  string req = "R1";

  // reference model state
  int unsigned m_rc = 0;
  bit m_armed = 0, m_hold = 0;
  int unsigned m_start = 0, m_end = 0;

  always #5 clk = ~clk;

  rpt_loop_seq u_rpt_loop_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_is_detect(ret_is_detect),
    .ret_in_slot(ret_in_slot), .ret_br_taken(ret_br_taken), .exc_abort(exc_abort),
    .irq_req(irq_req), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .exc_hold(exc_hold), .irq_accept(irq_accept), .status(status)
  );

  task automatic check(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_sel = 2'd3; cfg_wdata = '0;
    ret_valid = 0; ret_pc = '0; ret_is_detect = 0; ret_in_slot = 0; ret_br_taken = 0;
    exc_abort = 0;
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic step();
    bit at_end, back, fin, arm, abort;
    #1;
    at_end = ret_valid && (ret_pc == m_end);
    abort  = m_armed && exc_abort;
    back   = m_armed && !exc_abort && at_end && m_rc > 1;
    fin    = m_armed && !exc_abort && at_end && m_rc == 1;
    arm    = !m_armed && ret_valid && ret_is_detect && !(ret_in_slot && ret_br_taken) && m_rc != 0;
    check("redir_valid", redir_valid, back);
    if (back) check("redir_pc", redir_pc, m_start);
    check("irq_accept", irq_accept, irq_req && !m_hold);
    @(posedge clk);
    if (rst) begin
      m_rc = 0; m_armed = 0; m_hold = 0; m_start = 0; m_end = 0;
    end else begin
      if (cfg_wr && !m_armed && !arm) begin
        if (cfg_sel == 2'd0) m_start = cfg_wdata;
        if (cfg_sel == 2'd1) m_end = cfg_wdata;
        if (cfg_sel == 2'd2) m_rc = cfg_wdata[11:0];
      end
      if (fin) m_rc = 0;
      else if (back) m_rc = m_rc - 1;
      if (arm) begin m_armed = 1; m_hold = 1; end
      if (abort || fin) begin m_armed = 0; m_hold = 0; end
    end
    @(negedge clk);
    check("status", status, {m_armed, m_hold, 12'(m_rc)});
    idle_inputs();
  endtask

  task automatic wr(int sel, int unsigned val);
    cfg_wr = 1; cfg_sel = 2'(sel); cfg_wdata = val;
    step();
  endtask

  task automatic retire(int unsigned pc, bit det, bit slot, bit tkn);
    ret_valid = 1; ret_pc = pc; ret_is_detect = det; ret_in_slot = slot; ret_br_taken = tkn;
    step();
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs(); irq_req = 0; rst = 1;
    @(negedge clk);
    step(); step();
    rst = 0;
    req = "R1"; step();
    check("reset status", status, 0);

    req = "R2";
    wr(0, 32'h100); wr(1, 32'h10C); wr(2, 3); wr(3, 32'hFFF);
    check("count loaded", status[11:0], 3);

    req = "R3"; // branch lands after detection instruction
    retire(32'h104, 0, 0, 0);
    check("no arm on skip", status[13], 0);
    check("count unchanged", status[11:0], 3);

    req = "R4"; // detection in slot of taken branch
    retire(32'h0FC, 1, 1, 1);
    check("no arm when taken", status[13], 0);

    req = "R4"; // not-taken slot arms
    retire(32'h0FC, 1, 1, 0);
    check("armed from slot", status[13], 1);

    req = "R7";
    irq_req = 1;
    for (int it = 0; it < 3; it++) begin
      for (int k = 0; k < 4; k++) begin
        req = (k == 3) ? ((it == 2) ? "R6" : "R5") : "R7";
        if (it == 1 && k == 1) begin req = "R9"; wr(2, 9); req = "R10"; end
        if (it == 1 && k == 2) begin retire(32'h0FC, 1, 0, 0); req = "R7"; end
        retire(32'h100 + 4*k, 0, 0, 0);
      end
    end
    req = "R6";
    check("disarmed", status[13:12], 0);
    check("count zero", status[11:0], 0);
    req = "R7"; step();
    check("irq released", irq_accept, 1);
    irq_req = 0;

    req = "R9"; wr(0, 32'h200); wr(1, 32'h208); wr(2, 5);
    req = "R3"; retire(32'h1FC, 1, 0, 0);
    req = "R5"; retire(32'h200, 0, 0, 0); retire(32'h204, 0, 0, 0); retire(32'h208, 0, 0, 0);
    check("count dec", status[11:0], 4);
    req = "R8";
    exc_abort = 1; ret_valid = 1; ret_pc = 32'h208; step();
    check("abort drop", status[13:12], 0);
    check("abort keeps count", status[11:0], 4);
    retire(32'h208, 0, 0, 0);

    req = "R3"; wr(2, 0); retire(32'h1FC, 1, 0, 0);
    check("zero count no arm", status[13], 0);

    req = "R1"; wr(2, 7); retire(32'h1FC, 1, 0, 0);
    rst = 1; step(); rst = 0;
    check("mid reset", status, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule